// File: doc/BRIEF.md
# Double-Buffered Serial DAC Front End

This block is the digital side of a 12-bit voltage-output converter. A host shifts a code in over three wires: serial data, serial clock and an active-low select. A separate active-low load pin copies the shifted word into a holding register, and the holding register drives the converter. Because the two registers are separate, a new word can be shifted in while the output keeps its old code. An active-low clear pin forces the holding register to zero scale whenever it is held low.

The block runs on a fast system clock. The serial clock and the select, load, clear and data pins each pass through a two-flop synchronizer. A serial-clock rising edge is found by comparing successive synchronized samples, so the system clock must run at least four times faster than the serial clock. The outputs are the 12-bit holding code, in straight unipolar binary (0x000 is zero scale, 0xFFF is full scale, one LSB per 0.5 mV step), and a flag that marks zero scale.

Top module: `serdac_front`

## Requirements
- R1: After system reset, the shift register and the holding register are both zero, and the zero-scale flag is high.
- R2: Each synchronized rising edge of the serial clock, while select is low, shifts the data bit into bit 0 of the shift register. Earlier bits move toward bit 11, so a 12-bit word arrives most-significant bit first.
- R3: While select is high, serial-clock edges leave the shift register unchanged.
- R4: A load transfer takes place at any level of the select pin.
- R5: While load is high and clear is high, the holding code does not change, including while a word is being shifted in.
- R6: While load is low, the holding code follows the shift register, so a partial word reaches the output. When load returns high, the code keeps the last value it took.
- R7: While clear is low, the holding code is 0x000. Clear does not change the shift register, so a later load restores the shifted word.
- R8: When clear and load are both low, clear wins and the code stays 0x000.
- R9: The zero-scale flag is high exactly when the holding code is 0x000.
- R10: A falling edge on the load pin or on the clear pin changes the holding code on the third system-clock edge after the pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_data | input | 1 | Serial data, most-significant bit first |
| sel_n | input | 1 | Active-low select; gates shifting only |
| load_n | input | 1 | Active-low, level-sensitive transfer strobe |
| clear_n | input | 1 | Active-low clear of the holding register |
| dac_code | output | 12 | Holding-register code for the converter |
| zero_scale | output | 1 | High when dac_code is 0x000 |

## Verification
A pin change is seen inside the block two system-clock edges after it happens. A load or clear therefore changes the code on the third edge, and a serial-clock rise updates the shift register on the third edge and the transparent code on the fourth. The bench drives pins on falling system-clock edges and samples on falling edges. For the R10 latency it samples two edges after the drive, expecting the old code, and three edges after, expecting the new code. Everything else it samples at least four edges after the last pin change. During shifting with load high it compares the code on every cycle.

// File: rtl/serdac_front.sv
module serdac_front #(
  parameter int WIDTH = 12,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_data,
  input  logic             sel_n,
  input  logic             load_n,
  input  logic             clear_n,
  output logic [WIDTH-1:0] dac_code,
  output logic             zero_scale
);
  localparam int NPIN = 5;
  localparam logic [NPIN-1:0] PIN_IDLE = 5'b00111;

  logic [NPIN-1:0] pin_now;
  logic [NPIN-1:0] sync_q [SYNC];
  logic            data_s, sclk_s, sel_s, load_s, clear_s;
  logic            sclk_d;
  logic            sclk_rise;
  logic [WIDTH-1:0] shift_q;
  logic [WIDTH-1:0] hold_q;

  assign pin_now = {ser_data, ser_clk, sel_n, load_n, clear_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC; i++) sync_q[i] <= PIN_IDLE;
    end else begin
      sync_q[0] <= pin_now;
      for (int i = 1; i < SYNC; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign {data_s, sclk_s, sel_s, load_s, clear_s} = sync_q[SYNC-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  assign sclk_rise = sclk_s & ~sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 shift_q <= '0;
    else if (sclk_rise && !sel_s) shift_q <= {shift_q[WIDTH-2:0], data_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (!clear_s) hold_q <= '0;
    else if (!load_s)  hold_q <= shift_q;
  end

  assign dac_code   = hold_q;
  assign zero_scale = (hold_q == '0);
endmodule

// File: rtl/serdac_front_chk.sv
module serdac_front_chk #(
  parameter int WIDTH = 12,
  parameter int SYNC  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel_n,
  input logic             load_n,
  input logic             clear_n,
  input logic [WIDTH-1:0] dac_code,
  input logic [WIDTH-1:0] shift_q
);
  if (SYNC == 2) begin : g_chk
    a_r5_code_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && $past(load_n,1) && $past(load_n,2) && $past(load_n,3) && $past(load_n,4) &&
       clear_n && $past(clear_n,1) && $past(clear_n,2) && $past(clear_n,3) && $past(clear_n,4))
      |-> $stable(dac_code));

    a_r3_sel_blocks_shift: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_n && $past(sel_n,1) && $past(sel_n,2) && $past(sel_n,3) && $past(sel_n,4))
      |-> $stable(shift_q));

    a_r6_load_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_n && !$past(load_n,1) && !$past(load_n,2) && !$past(load_n,3) && !$past(load_n,4) &&
       sel_n && $past(sel_n,1) && $past(sel_n,2) && $past(sel_n,3) && $past(sel_n,4) &&
       clear_n && $past(clear_n,1) && $past(clear_n,2) && $past(clear_n,3) && $past(clear_n,4))
      |-> dac_code == shift_q);

    a_r7_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear_n && !$past(clear_n,1) && !$past(clear_n,2) && !$past(clear_n,3))
      |-> dac_code == '0);

    a_r8_clear_beats_load: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(clear_n,3) && !$past(load_n,3)) |-> dac_code == '0);
  end
endmodule

bind serdac_front serdac_front_chk #(.WIDTH(WIDTH), .SYNC(SYNC)) chk_i (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .load_n(load_n), .clear_n(clear_n),
  .dac_code(dac_code), .shift_q(shift_q)
);

// File: tb/serdac_front_tb_top.sv
module serdac_front_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, sel_n = 1'b1, load_n = 1'b1, clear_n = 1'b1;
  logic [11:0] dac_code;
  logic zero_scale;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [11:0] m_sh = '0;
  logic [11:0] m_hold = '0;

  always #5 clk = ~clk;

  serdac_front dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .sel_n(sel_n), .load_n(load_n), .clear_n(clear_n),
    .dac_code(dac_code), .zero_scale(zero_scale)
  );

  // {sel_n, word}
  localparam logic [12:0] VEC [8] = '{
    {1'b0, 12'hA5C}, {1'b1, 12'h3F0}, {1'b0, 12'hFFF}, {1'b0, 12'h001},
    {1'b1, 12'h800}, {1'b0, 12'h800}, {1'b0, 12'h000}, {1'b0, 12'h7FF}
  };

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_flag();
    check("R9 zero flag", {11'd0, zero_scale}, {11'd0, (dac_code == 12'h000)});
  endtask

  // mode 0: no check, 1: code must hold, 2: code follows shift register
  task automatic shift_word(input logic [11:0] w, input logic cs, input int mode);
    for (int b = 11; b >= 0; b--) begin
      @(negedge clk);
      ser_data = w[b]; sel_n = cs; ser_clk = 1'b0;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        if (mode == 1) check("R5 code holds while shifting", dac_code, m_hold);
      end
      ser_clk = 1'b1;
      if (!cs) m_sh = {m_sh[10:0], w[b]};
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        if (mode == 1) check("R5 code holds while shifting", dac_code, m_hold);
      end
      if (mode == 2) begin
        m_hold = m_sh;
        check("R6 transparent load follows shift", dac_code, m_hold);
      end
    end
    @(negedge clk);
    ser_clk = 1'b0; sel_n = 1'b1;
  endtask

  task automatic pulse_load();
    @(negedge clk);
    load_n = 1'b0;
    repeat (6) @(negedge clk);
    load_n = 1'b1;
    m_hold = m_sh;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset code", dac_code, 12'h000);
    check("R1 reset flag", {11'd0, zero_scale}, 12'h001);

    // table walk: shift with load high (R5, R3), then load with select high (R2, R4)
    foreach (VEC[i]) begin
      shift_word(VEC[i][11:0], VEC[i][12], 1);
      pulse_load();
      check(VEC[i][12] ? "R3 ignored shift then load" : "R2 R4 loaded word", dac_code, m_hold);
      check_flag();
    end

    // random words, select toggling
    for (int n = 0; n < 6; n++) begin
      logic [11:0] w;
      logic cs;
      w = 12'($urandom);
      cs = n[0];
      shift_word(w, cs, 1);
      pulse_load();
      check("R2 R3 random word", dac_code, m_hold);
    end

    // R10: load latency of three system edges
    shift_word(12'h9C3, 1'b0, 1);
    @(negedge clk);
    load_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 load not yet applied", dac_code, m_hold);
    @(negedge clk);
    m_hold = m_sh;
    check("R10 load applied on third edge", dac_code, m_hold);
    repeat (2) @(negedge clk);
    load_n = 1'b1;
    repeat (4) @(negedge clk);

    // R6: transparent load with a partial word, then retention
    @(negedge clk);
    load_n = 1'b0;
    shift_word(12'h5A3, 1'b0, 2);
    @(negedge clk);
    load_n = 1'b1;
    repeat (4) @(negedge clk);
    shift_word(12'h0F0, 1'b0, 1);
    check("R6 code retained after load high", dac_code, 12'h5A3);

    // R7: clear, latency and preserved shift register
    @(negedge clk);
    clear_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 clear not yet applied", dac_code, m_hold);
    @(negedge clk);
    m_hold = '0;
    check("R7 clear forces zero", dac_code, 12'h000);
    check_flag();
    repeat (3) @(negedge clk);
    clear_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R7 zero held after clear", dac_code, 12'h000);
    pulse_load();
    check("R7 shift register kept through clear", dac_code, 12'h0F0);

    // R8: clear and load together
    shift_word(12'h321, 1'b0, 1);
    @(negedge clk);
    clear_n = 1'b0; load_n = 1'b0;
    repeat (6) @(negedge clk);
    check("R8 clear wins over load", dac_code, 12'h000);
    check_flag();
    clear_n = 1'b1;
    repeat (4) @(negedge clk);
    m_hold = m_sh;
    check("R8 load resumes after clear", dac_code, 12'h321);
    load_n = 1'b1;
    repeat (4) @(negedge clk);
    check_flag();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule